// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block takes one fast source clock, the modelled output of the frequency synthesizer, and derives four groups of clocks from it: a CPU group, a stoppable PCI group, a single PCI clock that is never stopped by the stop controls, and a reference clock. All groups share one phase counter, so CPU rising edges line up with PCI rising edges. A speed-select input picks a CPU-to-PCI ratio of three or two.

Three active-low control inputs (CPU halt, PCI halt and power-down) arrive asynchronously. Each passes through a two-flop synchronizer. A group's enable is sampled only on the cycle where that group's clock falls. A stopped clock therefore always parks low, and every high pulse that leaves the block has its full width. Power-down overrides both halt inputs and also gates the free-running PCI clock and the reference clock. It drops the oscillator and PLL enables. When power returns, a settling timer that counts reference periods holds every output low until it expires.

Top module: `clkctl_top`

## Requirements
- R1: During and right after reset, every clock output, `osc_en` and `pll_en` are low.
- R2: While `cpu_halt_n` is low, every CPU output stays low. While it is high (and power is settled), the CPU outputs toggle.
- R3: While `pci_halt_n` is low, every stoppable PCI output stays low. While it is high, they toggle at one PCI period of `PCI_DIV` source cycles.
- R4: Every high pulse on a gated output lasts exactly half its period: CPU_DIV/2 cycles for CPU, PCI_DIV/2 cycles for PCI. A disabled output is low.
- R5: With `speed_sel` high the CPU period is `CPU_DIV_FAST` (3 CPU rises per PCI period at default). With it low the period is `CPU_DIV_SLOW` (2 per PCI period). A change of selection takes effect only at the start of a PCI period.
- R6: From a change on either halt input to the first affected edge (the first missing rise, or the first restored rise), at most one rising edge of the free-running PCI clock occurs.
- R7: `osc_en` and `pll_en` fall on the third source clock edge after `pwr_up_n` goes low. When power returns, `osc_en` rises on the third edge and `pll_en` one edge later. While powered down, no output toggles, the free-running PCI and reference clocks included.
- R8: After power is restored, or after reset, no output rises until `WAKE_TICKS` reference periods have passed. The outputs then start within about two PCI periods.
- R9: While powered and settled, the free-running PCI clock toggles whatever the halt inputs are.
- R10: While powered and settled, the reference clock has a period of `REF_DIV` source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock (modelled synthesizer output) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_halt_n | input | 1 | Active-low CPU clock stop, asynchronous |
| pci_halt_n | input | 1 | Active-low PCI clock stop, asynchronous |
| pwr_up_n | input | 1 | Active-low power-down, asynchronous |
| speed_sel | input | 1 | 1 = fast CPU ratio, 0 = slow CPU ratio |
| cpu_clk | output | N_CPU | Gated CPU clocks |
| pci_clk | output | N_PCI | Gated stoppable PCI clocks |
| pci_clk_free | output | 1 | PCI clock gated by power-down only |
| ref_clk | output | 1 | Reference clock, gated by power-down only |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The oscillator and PLL enables are due a fixed number of edges after power-down moves: two synchronizer edges plus one register, and one more edge for the PLL on the way up. The bench samples them on exactly those cycles. Output gating is not at a fixed cycle, because it waits for the clock's falling point. The bench therefore measures the latency of each halt edge as a count of free-running PCI rises. It repeats this at every input phase inside a PCI period and compares the count with the bound of one. Steady-state behaviour is checked by counting rises in a 24-cycle window after a 40-cycle settling wait, which is longer than any synchronizer, selection or falling-point delay. Pulse widths are watched on every cycle of the run.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  // Square-wave level for a phase inside a period: high in the first half.
  function automatic logic phase_high(input int unsigned ph, input int unsigned period);
    return (ph % period) < (period / 2);
  endfunction

  // Next phase of a wrapping counter.
  function automatic int unsigned phase_step(input int unsigned ph, input int unsigned period);
    return (ph + 1 >= period) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate #(
  parameter int N_OUT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_now,
  input  logic             raw_next,
  input  logic             en_req,
  output logic             en_q,
  output logic [N_OUT-1:0] clk_out
);
  logic fall_point;

  // The enable may only move when the clock is about to go low.
  assign fall_point = raw_now & ~raw_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_q <= 1'b0;
    else if (fall_point) en_q <= en_req;
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_out[i] <= 1'b0;
      else        clk_out[i] <= raw_next & en_q;
    end
  end
endmodule

// File: rtl/clkctl_wake.sv
module clkctl_wake #(
  parameter int TICKS = 42955,
  parameter int W     = $clog2(TICKS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         powered,
  input  logic         tick,
  output logic         ready,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LIMIT = W'(TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (!powered)              count <= '0;
    else if (tick && count != LIMIT) count <= count + 1'b1;
  end

  assign ready = (count == LIMIT);
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top #(
  parameter int N_CPU        = 2,
  parameter int N_PCI        = 5,
  parameter int PCI_DIV      = 12,
  parameter int CPU_DIV_FAST = 4,
  parameter int CPU_DIV_SLOW = 6,
  parameter int REF_DIV      = 8,
  parameter int WAKE_TICKS   = 42955,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             cpu_halt_n,
  input  logic             pci_halt_n,
  input  logic             pwr_up_n,
  input  logic             speed_sel,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic             pci_clk_free,
  output logic             ref_clk,
  output logic             osc_en,
  output logic             pll_en
);
  import clkctl_pkg::*;

  localparam int PH_W = $clog2(PCI_DIV);
  localparam int RF_W = $clog2(REF_DIV);
  localparam int WK_W = $clog2(WAKE_TICKS + 1);

  // Synchronized controls
  logic [3:0] sync_in, sync_out;
  logic       cpu_halt_s, pci_halt_s, pwr_s, sel_s;

  assign sync_in = {speed_sel, pwr_up_n, pci_halt_n, cpu_halt_n};

  clkctl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_src),
    .rst_n(rst_n),
    .din  (sync_in),
    .dout (sync_out)
  );

  assign cpu_halt_s = sync_out[0];
  assign pci_halt_s = sync_out[1];
  assign pwr_s      = sync_out[2];
  assign sel_s      = sync_out[3];

  // Shared phase counters
  logic [PH_W-1:0] ph_q, ph_nxt;
  logic [RF_W-1:0] rf_q, rf_nxt;
  logic            sel_q;
  logic            ref_tick;
  int unsigned     cpu_div;

  assign ph_nxt   = PH_W'(phase_step(32'(ph_q), PCI_DIV));
  assign rf_nxt   = RF_W'(phase_step(32'(rf_q), REF_DIV));
  assign ref_tick = (rf_nxt == '0);
  assign cpu_div  = sel_q ? CPU_DIV_FAST : CPU_DIV_SLOW;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      rf_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      ph_q <= ph_nxt;
      rf_q <= rf_nxt;
      if (ph_nxt == '0) sel_q <= sel_s;   // ratio moves only at a PCI period start
    end
  end

  // Power sequencing: oscillator first, PLL one edge later
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      osc_en <= 1'b0;
      pll_en <= 1'b0;
    end else begin
      osc_en <= pwr_s;
      pll_en <= osc_en & pwr_s;
    end
  end

  logic            wake_ready;
  logic [WK_W-1:0] wake_cnt;

  clkctl_wake #(.TICKS(WAKE_TICKS), .W(WK_W)) u_wake (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .powered(pwr_s),
    .tick   (ref_tick),
    .ready  (wake_ready),
    .count  (wake_cnt)
  );

  // Raw waveforms, current and next cycle
  logic cpu_now, cpu_next, pci_now, pci_next, ref_now, ref_next;

  assign cpu_now  = phase_high(32'(ph_q),   cpu_div);
  assign cpu_next = phase_high(32'(ph_nxt), cpu_div);
  assign pci_now  = phase_high(32'(ph_q),   PCI_DIV);
  assign pci_next = phase_high(32'(ph_nxt), PCI_DIV);
  assign ref_now  = phase_high(32'(rf_q),   REF_DIV);
  assign ref_next = phase_high(32'(rf_nxt), REF_DIV);

  // Enable requests: power-down overrides the halt inputs
  logic req_cpu, req_pci, req_free;
  logic en_cpu_q, en_pci_q, en_free_q, en_ref_q;
  logic [0:0] free_vec, ref_vec;

  assign req_cpu  = wake_ready & cpu_halt_s;
  assign req_pci  = wake_ready & pci_halt_s;
  assign req_free = wake_ready;

  clkctl_gate #(.N_OUT(N_CPU)) u_gate_cpu (
    .clk(clk_src), .rst_n(rst_n), .raw_now(cpu_now), .raw_next(cpu_next),
    .en_req(req_cpu), .en_q(en_cpu_q), .clk_out(cpu_clk)
  );

  clkctl_gate #(.N_OUT(N_PCI)) u_gate_pci (
    .clk(clk_src), .rst_n(rst_n), .raw_now(pci_now), .raw_next(pci_next),
    .en_req(req_pci), .en_q(en_pci_q), .clk_out(pci_clk)
  );

  clkctl_gate #(.N_OUT(1)) u_gate_free (
    .clk(clk_src), .rst_n(rst_n), .raw_now(pci_now), .raw_next(pci_next),
    .en_req(req_free), .en_q(en_free_q), .clk_out(free_vec)
  );

  clkctl_gate #(.N_OUT(1)) u_gate_ref (
    .clk(clk_src), .rst_n(rst_n), .raw_now(ref_now), .raw_next(ref_next),
    .en_req(req_free), .en_q(en_ref_q), .clk_out(ref_vec)
  );

  assign pci_clk_free = free_vec[0];
  assign ref_clk      = ref_vec[0];
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk #(
  parameter int PH_W       = 4,
  parameter int WK_W       = 16,
  parameter int WAKE_TICKS = 42955
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu0,
  input logic            pci0,
  input logic            osc_en,
  input logic            pll_en,
  input logic            pwr_s,
  input logic            ready,
  input logic            en_cpu_q,
  input logic            en_pci_q,
  input logic            sel_q,
  input logic [PH_W-1:0] phase,
  input logic [WK_W-1:0] wake_cnt
);
  a_r7_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> !osc_en);

  a_r7_pll_order: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> osc_en);

  a_r2_cpu_park: assert property (@(posedge clk) disable iff (!rst_n)
    !en_cpu_q |-> !cpu0);

  a_r3_pci_park: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pci_q |-> !pci0);

  a_r4_cpu_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu0) |=> cpu0);

  a_r4_pci_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci0) |=> pci0);

  a_r5_sel_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> (phase == '0));

  a_r8_ready_powered: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(pwr_s));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cnt <= WK_W'(WAKE_TICKS));
endmodule

bind clkctl_top clkctl_chk #(
  .PH_W(PH_W), .WK_W(WK_W), .WAKE_TICKS(WAKE_TICKS)
) u_chk (
  .clk     (clk_src),
  .rst_n   (rst_n),
  .cpu0    (cpu_clk[0]),
  .pci0    (pci_clk[0]),
  .osc_en  (osc_en),
  .pll_en  (pll_en),
  .pwr_s   (pwr_s),
  .ready   (wake_ready),
  .en_cpu_q(en_cpu_q),
  .en_pci_q(en_pci_q),
  .sel_q   (sel_q),
  .phase   (ph_q),
  .wake_cnt(wake_cnt)
);

// File: tb/clkctl_top_bench.sv
module clkctl_top_bench;
  localparam int B_WAKE = 10;
  localparam int B_REF  = 8;
  localparam int B_PCI  = 12;
  localparam int LOW_T  = (B_WAKE - 1) * B_REF + 2;
  localparam int HIGH_T = (B_WAKE + 1) * B_REF + 2 * B_PCI + 4;

  // sel, cpu_halt_n, pci_halt_n, expected cpu rises, expected pci rises (per 24 cycles)
  localparam int VEC [6][5] = '{
    '{1, 1, 1, 6, 2},
    '{0, 1, 1, 4, 2},
    '{1, 0, 1, 0, 2},
    '{1, 1, 0, 6, 0},
    '{0, 0, 0, 0, 0},
    '{0, 1, 0, 4, 0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_halt_n = 1'b1, pci_halt_n = 1'b1, pwr_up_n = 1'b1, speed_sel = 1'b1;
  logic [1:0] cpu_clk;
  logic [4:0] pci_clk;
  logic       pci_clk_free, ref_clk, osc_en, pll_en;

  int n_cmp = 0, n_bad = 0;
  int r_cpu0, r_cpu1, r_pci0, r_pci4, r_free, r_ref;

  always #2 clk = ~clk;

  clkctl_top #(.WAKE_TICKS(B_WAKE), .REF_DIV(B_REF), .PCI_DIV(B_PCI)) u_clkctl_top (
    .clk_src(clk), .rst_n(rst_n), .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n),
    .pwr_up_n(pwr_up_n), .speed_sel(speed_sel), .cpu_clk(cpu_clk), .pci_clk(pci_clk),
    .pci_clk_free(pci_clk_free), .ref_clk(ref_clk), .osc_en(osc_en), .pll_en(pll_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Count rises over 24 transitions, sampled at negedges
  task automatic count_rises();
    logic [5:0] prev, cur;
    r_cpu0 = 0; r_cpu1 = 0; r_pci0 = 0; r_pci4 = 0; r_free = 0; r_ref = 0;
    @(negedge clk);
    prev = {cpu_clk[0], cpu_clk[1], pci_clk[0], pci_clk[4], pci_clk_free, ref_clk};
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      cur = {cpu_clk[0], cpu_clk[1], pci_clk[0], pci_clk[4], pci_clk_free, ref_clk};
      if (cur[5] && !prev[5]) r_cpu0++;
      if (cur[4] && !prev[4]) r_cpu1++;
      if (cur[3] && !prev[3]) r_pci0++;
      if (cur[2] && !prev[2]) r_pci4++;
      if (cur[1] && !prev[1]) r_free++;
      if (cur[0] && !prev[0]) r_ref++;
      prev = cur;
    end
  endtask

  // Pulse width watch (R4, R5)
  int hi_cpu = 0, hi_pci = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_clk[0]) hi_cpu++;
      else begin
        if (hi_cpu != 0) check(hi_cpu == 2 || hi_cpu == 3, "R4/R5 cpu high width", hi_cpu, 2);
        hi_cpu = 0;
      end
      if (pci_clk[0]) hi_pci++;
      else begin
        if (hi_pci != 0) check(hi_pci == B_PCI / 2, "R4 pci high width", hi_pci, B_PCI / 2);
        hi_pci = 0;
      end
    end
  end

  // Latency of one halt edge, counted in free-running PCI rises (R6)
  task automatic lat_run(input bit on_cpu, input bit going_low, input int offset, input int per);
    int   last_rise, first_rise, edge_t, nfree;
    int   free_t [8];
    logic ptgt, pfree, tgt;
    last_rise = -1; first_rise = -1; nfree = 0;
    repeat (offset) @(negedge clk);
    ptgt  = on_cpu ? cpu_clk[0] : pci_clk[0];
    pfree = pci_clk_free;
    if (on_cpu) cpu_halt_n = !going_low;
    else        pci_halt_n = !going_low;
    for (int t = 1; t <= 48; t++) begin
      @(negedge clk);
      tgt = on_cpu ? cpu_clk[0] : pci_clk[0];
      if (tgt && !ptgt) begin
        last_rise = t;
        if (first_rise < 0) first_rise = t;
      end
      if (pci_clk_free && !pfree && nfree < 8) begin
        free_t[nfree] = t;
        nfree++;
      end
      ptgt = tgt; pfree = pci_clk_free;
    end
    if (going_low) edge_t = (last_rise < 0) ? 0 : last_rise + per;
    else begin
      edge_t = first_rise;
      check(first_rise > 0, "R6 output restarts", first_rise, 1);
    end
    begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < nfree; k++) if (free_t[k] < edge_t) cnt++;
      check(cnt <= 1, on_cpu ? "R6 cpu halt latency" : "R6 pci halt latency", cnt, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int first_free, early;
    logic pc, pp, pf, prf, pcf;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(cpu_clk == 0 && pci_clk == 0 && !pci_clk_free && !ref_clk, "R1 outputs low in reset",
          {cpu_clk, pci_clk, pci_clk_free, ref_clk}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!osc_en && !pll_en, "R1 enables low after reset", {osc_en, pll_en}, 0);
    check(cpu_clk == 0 && pci_clk == 0 && !pci_clk_free, "R1 clocks low after reset",
          {cpu_clk, pci_clk, pci_clk_free}, 0);

    // R8: settle time after reset
    first_free = -1; early = 0; pf = 0; pc = 0; pp = 0; prf = 0;
    for (int t = 2; t <= 200 && first_free < 0; t++) begin
      @(negedge clk);
      if (t < LOW_T && ((cpu_clk[0] && !pc) || (pci_clk[0] && !pp) || (ref_clk && !prf))) early++;
      if (pci_clk_free && !pf) first_free = t;
      pc = cpu_clk[0]; pp = pci_clk[0]; pf = pci_clk_free; prf = ref_clk;
    end
    check(first_free >= LOW_T && first_free <= HIGH_T, "R8 first clock after reset wait",
          first_free, LOW_T);
    check(early == 0, "R8 no early rise after reset", early, 0);

    // Table walk: R2, R3, R5, R9, R10
    foreach (VEC[i]) begin
      @(negedge clk);
      speed_sel  = VEC[i][0][0];
      cpu_halt_n = VEC[i][1][0];
      pci_halt_n = VEC[i][2][0];
      repeat (40) @(negedge clk);
      count_rises();
      check(r_cpu0 == VEC[i][3], "R2/R5 cpu rises", r_cpu0, VEC[i][3]);
      check(r_cpu1 == VEC[i][3], "R2 cpu second output", r_cpu1, VEC[i][3]);
      check(r_pci0 == VEC[i][4], "R3 pci rises", r_pci0, VEC[i][4]);
      check(r_pci4 == VEC[i][4], "R3 pci last output", r_pci4, VEC[i][4]);
      check(r_free == 2, "R9 free-running pci", r_free, 2);
      check(r_ref == 24 / B_REF, "R10 reference period", r_ref, 24 / B_REF);
    end

    // R6: latency at every phase offset within a PCI period
    @(negedge clk);
    speed_sel = 1'b1; cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
    repeat (40) @(negedge clk);
    for (int off = 0; off < B_PCI; off++) begin
      lat_run(1'b1, 1'b1, off, 4);
      lat_run(1'b1, 1'b0, off + 1, 4);
      lat_run(1'b0, 1'b1, off, B_PCI);
      lat_run(1'b0, 1'b0, off + 1, B_PCI);
    end

    // R7: power-down timing and full gating
    repeat (20) @(negedge clk);
    pwr_up_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(osc_en && pll_en, "R7 enables held two edges", {osc_en, pll_en}, 3);
    @(negedge clk);
    check(!osc_en && !pll_en, "R7 enables drop on third edge", {osc_en, pll_en}, 0);
    repeat (30) @(negedge clk);
    count_rises();
    check(r_cpu0 + r_pci0 + r_free + r_ref == 0, "R7 all outputs quiet in power-down",
          r_cpu0 + r_pci0 + r_free + r_ref, 0);

    // R7/R8: power restore
    @(negedge clk);
    pwr_up_n = 1'b1;
    first_free = -1; early = 0; pf = pci_clk_free; pcf = cpu_clk[0];
    for (int t = 1; t <= 200 && first_free < 0; t++) begin
      @(negedge clk);
      if (t == 3) begin
        check(osc_en && !pll_en, "R7 osc before pll", {osc_en, pll_en}, 2);
      end
      if (t == 4) check(pll_en, "R7 pll one edge later", pll_en, 1);
      if (t < LOW_T && cpu_clk[0] && !pcf) early++;
      if (pci_clk_free && !pf) first_free = t;
      pf = pci_clk_free; pcf = cpu_clk[0];
    end
    check(first_free >= LOW_T && first_free <= HIGH_T, "R8 first clock after power restore",
          first_free, LOW_T);
    check(early == 0, "R8 no early cpu rise", early, 0);

    // R5: mid-period selection changes keep widths legal and final ratio right
    for (int k = 0; k < 6; k++) begin
      repeat (5 + k) @(negedge clk);
      speed_sel = ~speed_sel;
    end
    repeat (40) @(negedge clk);
    count_rises();
    check(r_cpu0 == (speed_sel ? 6 : 4), "R5 ratio after changes", r_cpu0, speed_sel ? 6 : 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule